// File: doc/BRIEF.md
# 32-bit SECDED Hamming Codec

This block protects a 32-bit word with a 39-bit single-error-correcting, double-error-detecting code. Its encoder half takes a data word and produces the codeword. The data bits are spread over the positions whose index is not a power of two. Six Hamming check bits sit at the power-of-two positions, and one overall parity bit sits at the end. Its decoder half takes a codeword that may have been corrupted in storage. It returns the recovered data word and a two-bit status saying whether the word was clean, was repaired, or cannot be trusted.

Both halves are purely combinational and independent of each other. A storage array places the encoder on its write path and the decoder on its read path. The two halves share no state, so a design can also use either one alone. Codeword positions are numbered 1 to 39, and position p maps to vector bit p-1. With three or more flipped bits the result is not guaranteed: the word may be mis-corrected or may look clean.

Top module: `secded32_codec`

## Requirements
- R1: The encoder places data bit 0 at position 3 and fills the remaining data bits, in ascending order, into the positions from 3 to 38 that are not powers of two, so data bit 31 lands at position 38; position p is vector bit p-1.
- R2: The check bit at position 2^k (k = 0..5, positions 1, 2, 4, 8, 16, 32) equals the XOR of every other position from 1 to 38 whose index has bit k set, so an encoded word has a zero syndrome.
- R3: Position 39 (vector bit 38) makes the XOR of all 39 codeword bits equal to zero.
- R4: A codeword with zero syndrome and even overall parity decodes to its embedded data with status 2'b00.
- R5: A single flipped bit at any position from 1 to 38 is corrected; the decoder returns the original data with status 2'b01.
- R6: A flip of position 39 alone gives status 2'b01 and the original data unchanged.
- R7: Any two flipped bits give status 2'b10, and the data is extracted from the received word without correction.
- R8: A nonzero syndrome above 38 with odd overall parity gives status 2'b10, and the data is extracted uncorrected.
- R9: The decoder never drives status 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 32 | Data word to encode |
| enc_word_o | output | 39 | Encoded codeword, position p on bit p-1 |
| dec_word_i | input | 39 | Received codeword to check and repair |
| dec_data_o | output | 32 | Recovered data word |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The encoder is checked against hand-derived codewords for zero, all ones, and a single set bit at the lowest and at the highest data position. These cases separate errors in data placement from errors in check-bit coverage. The decoder sees clean words, every single-bit flip, and every pair of flips, for several data patterns. A mistake in the syndrome-to-position mapping then shows up as wrong data under status 01. A missing overall-parity term shows up as a wrong status on pairs. A lone flip of the last bit, a pair of data flips, and a triple flip whose syndrome points beyond the word each test a separate branch of the correction decision.

// File: rtl/secded32_codec.sv
module secded32_codec #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         enc_data_i,
  output logic [DATA_W+6:0]         enc_word_o,
  input  logic [DATA_W+6:0]         dec_word_i,
  output logic [DATA_W-1:0]         dec_data_o,
  output logic [1:0]                dec_status_o
);
  localparam int CHK_W  = 6;
  localparam int WORD_W = DATA_W + CHK_W + 1;
  localparam int LAST   = WORD_W - 1;

  localparam logic [1:0] ST_CLEAN = 2'b00;
  localparam logic [1:0] ST_FIXED = 2'b01;
  localparam logic [1:0] ST_BAD   = 2'b10;

  function automatic logic is_pow2(input int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  function automatic logic [WORD_W-1:0] scatter(input logic [DATA_W-1:0] d);
    logic [WORD_W-1:0] w;
    int j;
    w = '0;
    j = 0;
    for (int pos = 1; pos <= LAST; pos++) begin
      if (!is_pow2(pos)) begin
        w[pos-1] = d[j];
        j++;
      end
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] gather(input logic [WORD_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int pos = 1; pos <= LAST; pos++) begin
      if (!is_pow2(pos)) begin
        d[j] = w[pos-1];
        j++;
      end
    end
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(input logic [WORD_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int pos = 1; pos <= LAST; pos++) begin
        if (((pos >> k) & 1) != 0) s[k] = s[k] ^ w[pos-1];
      end
    end
    return s;
  endfunction

  logic [WORD_W-1:0] enc_word;
  logic [WORD_W-1:0] fixed_word;
  logic [CHK_W-1:0]  syn;
  logic              odd;
  logic [1:0]        status;
  logic [DATA_W-1:0] raw_data;

  always_comb begin
    logic [CHK_W-1:0] chk;
    enc_word = scatter(enc_data_i);
    chk = syndrome(enc_word);
    for (int k = 0; k < CHK_W; k++) enc_word[(1 << k) - 1] = chk[k];
    enc_word[LAST] = ^enc_word[LAST-1:0];
    assert_enc_even_R3: assert (^enc_word == 1'b0)
      else $error("encoded word has odd overall parity");
    assert_enc_syndrome_zero_R2: assert (syndrome(enc_word) == '0)
      else $error("encoded word has nonzero syndrome");
  end

  assign enc_word_o = enc_word;
  assign raw_data   = gather(dec_word_i);

  always_comb begin
    syn        = syndrome(dec_word_i);
    odd        = ^dec_word_i;
    fixed_word = dec_word_i;
    status     = ST_CLEAN;
    if (syn == '0) begin
      if (odd) status = ST_FIXED;
    end else if (odd && int'(syn) <= LAST) begin
      for (int pos = 1; pos <= LAST; pos++) begin
        if (pos == int'(syn)) fixed_word[pos-1] = ~fixed_word[pos-1];
      end
      status = ST_FIXED;
    end else begin
      status = ST_BAD;
    end
  end

  assign dec_data_o   = gather(fixed_word);
  assign dec_status_o = status;

  always_comb begin
    assert_no_undef_status_R9: assert (status != 2'b11)
      else $error("undefined status driven");
    if (status == ST_CLEAN) begin
      assert_clean_passthru_R4: assert (gather(fixed_word) == raw_data)
        else $error("clean word altered on decode");
    end
    if (status == ST_BAD) begin
      assert_bad_uncorrected_R7: assert (fixed_word == dec_word_i)
        else $error("uncorrectable word was modified");
    end
  end
endmodule

// File: tb/sim_secded32_codec.sv
module sim_secded32_codec;
  logic        clk = 1'b0;
  logic [31:0] enc_data_i;
  logic [38:0] enc_word_o;
  logic [38:0] dec_word_i;
  logic [31:0] dec_data_o;
  logic [1:0]  dec_status_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  secded32_codec u0 (
    .enc_data_i  (enc_data_i),
    .enc_word_o  (enc_word_o),
    .dec_word_i  (dec_word_i),
    .dec_data_o  (dec_data_o),
    .dec_status_o(dec_status_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F96, 32'h1234_5678};

  task automatic t_reset_state;
    enc_data_i = '0; dec_word_i = '0; #1;
    chk("R1 zero encode", 64'(enc_word_o), 64'h0);
    chk("R4 zero decode status", 64'(dec_status_o), 64'h0);
    chk("R4 zero decode data", 64'(dec_data_o), 64'h0);
  endtask

  task automatic t_known_vectors;
    enc_data_i = 32'h0000_0001; #1;
    chk("R1 R2 R3 data bit0", 64'(enc_word_o), 64'h40_0000_0007);
    enc_data_i = 32'h8000_0000; #1;
    chk("R1 R2 R3 data bit31", 64'(enc_word_o), 64'h20_8000_000A);
    enc_data_i = 32'hFFFF_FFFF; #1;
    chk("R2 R3 all ones", 64'(enc_word_o), 64'h3F_7FFF_FFF4);
  endtask

  task automatic t_clean_roundtrip;
    foreach (pats[i]) begin
      enc_data_i = pats[i]; #1;
      chk("R3 even parity", 64'(^enc_word_o), 64'h0);
      dec_word_i = enc_word_o; #1;
      chk("R4 clean status", 64'(dec_status_o), 64'h0);
      chk("R4 clean data", 64'(dec_data_o), 64'(pats[i]));
    end
  endtask

  task automatic t_single_flips;
    foreach (pats[i]) begin
      enc_data_i = pats[i]; #1;
      for (int p = 0; p < 38; p++) begin
        dec_word_i = enc_word_o ^ (39'd1 << p); #1;
        chk("R5 single status", 64'(dec_status_o), 64'h1);
        chk("R5 single data", 64'(dec_data_o), 64'(pats[i]));
      end
    end
  endtask

  task automatic t_extra_bit;
    foreach (pats[i]) begin
      enc_data_i = pats[i]; #1;
      dec_word_i = enc_word_o ^ (39'd1 << 38); #1;
      chk("R6 last bit status", 64'(dec_status_o), 64'h1);
      chk("R6 last bit data", 64'(dec_data_o), 64'(pats[i]));
    end
  endtask

  task automatic t_double_flips;
    foreach (pats[i]) begin
      enc_data_i = pats[i]; #1;
      for (int a = 0; a < 39; a++) begin
        for (int b = a + 1; b < 39; b++) begin
          dec_word_i = enc_word_o ^ (39'd1 << a) ^ (39'd1 << b); #1;
          if (dec_status_o !== 2'b10) chk("R7 double status", 64'(dec_status_o), 64'h2);
          else checks++;
          if (dec_status_o === 2'b11) chk("R9 no status 11", 64'(dec_status_o), 64'h2);
        end
      end
      dec_word_i = enc_word_o ^ (39'd1 << 2) ^ (39'd1 << 4); #1;
      chk("R7 data flips kept", 64'(dec_data_o), 64'(pats[i] ^ 32'h3));
    end
  endtask

  task automatic t_syndrome_overrange;
    enc_data_i = 32'h1234_5678; #1;
    dec_word_i = enc_word_o ^ (39'd1 << 31) ^ (39'd1 << 7) ^ (39'd1 << 6); #1;
    chk("R8 overrange status", 64'(dec_status_o), 64'h2);
    chk("R8 overrange data", 64'(dec_data_o), 64'(32'h1234_5678 ^ 32'h8));
  endtask

  initial begin
    t_reset_state();
    t_known_vectors();
    t_clean_roundtrip();
    t_single_flips();
    t_extra_bit();
    t_double_flips();
    t_syndrome_overrange();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule